// File: doc/BRIEF.md
# I2C Byte-Handshake Master Controller

This block is a register-mapped master for a two-wire I2C bus that moves exactly one byte per software handshake. Software programs a clock prescaler and divisor, loads the data register with a target address and writes the status register to launch a START. After every address or data byte the block raises a pending flag and holds SCL low. It releases SCL only when software writes that flag back to zero, and that write also starts the next byte, a queued repeated START or a queued STOP.

Both bus lines are driven open-drain. An output of 1 on `scl_oe` or `sda_oe` pulls the line low, and 0 releases it to the external pull-up. The block supports master transmit and master receive. In receive mode, software can withdraw acknowledge generation just before the final byte so that the last byte is answered with NACK.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset all four registers read 0, `irq` is 0, and both `scl_oe` and `sda_oe` are 0, so the bus is released.
- R2: Register addresses are 0 control, 1 status, 2 data and 3 own address. The own-address register reads back what was written. Control bit 4 (pending) cannot be set by a software write of 1, and a write with bit 4 = 0 clears it.
- R3: A status write with bits 7:6 = 1x (11 transmit, 10 receive), bit 5 = 1 and bit 4 (output enable) = 1 while the bus is idle generates a START and sends the data register, MSB first, as the address byte. Status bit 5 then reads 1 (busy). The same write with bit 4 = 0 is ignored.
- R4: Control bit 4 (pending) is set at the end of every address or data byte. `irq` equals pending AND control bit 5.
- R5: While pending is set during a transfer, SCL stays pulled low and no bus activity happens.
- R6: Status bit 0 holds the SDA level sampled in the ninth SCL high phase of the latest byte: 0 means ACK and 1 means NACK.
- R7: In transmit mode (status bits 7:6 = 11), clearing pending sends the current data register contents as the next byte, MSB first.
- R8: In receive mode (status bits 7:6 = 10), clearing pending clocks in one byte. That byte is in the data register when pending sets. The master drives ACK on the ninth clock when control bit 7 is 1 (the value in the same clearing write counts) and NACK when it is 0.
- R9: A status write with bits 7:6 = 1x and bit 5 = 0 during a transfer queues a STOP, which is issued only when pending is cleared. Busy drops after SDA rises with SCL high. The same write while idle has no bus effect.
- R10: A START request written while pending is set is queued. Clearing pending then issues a repeated START followed by the address byte.
- R11: The SCL period is the prescaler times (control bits 3:0 + 1) clock cycles, where the prescaler is 512 when control bit 6 is set and 16 when it is clear.
- R12: SDA changes while SCL is released only during START and STOP generation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
The byte engine is run with a slave model on the wired-AND bus, using several patterns. An addressed write separates correct address shifting and acknowledgment from a mismatched address that must read NACK. A two-byte read with acknowledge generation withdrawn before the last byte shows that the ACK/NACK drive follows the clearing write. A write followed by a queued repeated START and a read shows that queued actions wait for the pending clear. Divisor 2 and the large prescaler measure SCL periods, and the ignored cases (START without output enable, STOP while idle, pending write of 1, masked interrupt) are observed at the bus and register ports.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_START,
      ENG_BIT,
      ENG_HOLD,
      ENG_STOP
   } eng_state_t;

   typedef enum logic [1:0] {
      CMD_START,
      CMD_BYTE,
      CMD_STOP
   } eng_cmd_t;

   typedef enum logic [1:0] {
      Q_NONE,
      Q_START,
      Q_STOP
   } queued_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;
   localparam logic [1:0] ADDR_OWN  = 2'd3;

   localparam int CB_ACKEN  = 7;
   localparam int CB_PRESEL = 6;
   localparam int CB_IE     = 5;
   localparam int CB_PEND   = 4;

   localparam int SB_MASTER = 7;
   localparam int SB_MTX    = 6;
   localparam int SB_STRT   = 5;
   localparam int SB_TXEN   = 4;

   localparam logic [1:0] MODE_MT = 2'b11;

endpackage

// File: rtl/i2cm_quarter_gen.sv
module i2cm_quarter_gen #(
   parameter int PRE_A = 16,
   parameter int PRE_B = 512,
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             pre_sel,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int QA    = PRE_A / 4;
   localparam int QB    = PRE_B / 4;
   localparam int CNT_W = $clog2(QB * (2 ** DIV_W) + 1);

   if ((PRE_A % 4) != 0 || (PRE_B % 4) != 0) begin : g_bad_pre
      $error("prescaler values must be multiples of four");
   end
   if (PRE_A >= PRE_B) begin : g_bad_order
      $error("PRE_A must be smaller than PRE_B");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] lim;

   always_comb begin
      base = pre_sel ? CNT_W'(QB) : CNT_W'(QA);
      lim  = base * (CNT_W'(div) + CNT_W'(1)) - CNT_W'(1);
   end

   assign tick = en && (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en || tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   // R11: every quarter starts counting from zero when the engine becomes active
   assert_cnt_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

endmodule

// File: rtl/i2cm_in_sync.sv
module i2cm_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0 || STAGES > 3) begin : g_bad_stages
      $error("STAGES must be between 0 and 3");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_ff
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '1;
         else        sr <= (sr << 1) | STAGES'(d);
      end
      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
   import i2cm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  eng_cmd_t   cmd,
   input  logic [7:0] cmd_byte,
   input  logic       cmd_tx,
   input  logic       cmd_ack_drive,
   input  logic       tick,
   input  logic       sda_s,
   output logic       run,
   output logic       ready,
   output logic       busy,
   output logic       byte_done,
   output logic       was_rx,
   output logic [7:0] rx_byte,
   output logic       ack_seen,
   output logic       scl_oe,
   output logic       sda_oe
);
   eng_state_t st;
   logic [1:0] ph;
   logic [3:0] bitn;
   logic [7:0] sh;
   logic       tx;
   logic       ackd;

   assign run     = (st == ENG_START) || (st == ENG_BIT) || (st == ENG_STOP);
   assign ready   = (st == ENG_IDLE) || (st == ENG_HOLD);
   assign was_rx  = !tx;
   assign rx_byte = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ENG_IDLE;
         ph        <= 2'd0;
         bitn      <= 4'd0;
         sh        <= 8'd0;
         tx        <= 1'b0;
         ackd      <= 1'b0;
         busy      <= 1'b0;
         byte_done <= 1'b0;
         ack_seen  <= 1'b0;
         scl_oe    <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         case (st)
            ENG_IDLE, ENG_HOLD: begin
               if (cmd_valid) begin
                  ph <= 2'd0;
                  case (cmd)
                     CMD_START: begin
                        st     <= ENG_START;
                        sh     <= cmd_byte;
                        tx     <= 1'b1;
                        busy   <= 1'b1;
                        sda_oe <= 1'b0;
                     end
                     CMD_BYTE: begin
                        st     <= ENG_BIT;
                        bitn   <= 4'd0;
                        sh     <= cmd_byte;
                        tx     <= cmd_tx;
                        ackd   <= cmd_ack_drive;
                        sda_oe <= cmd_tx & ~cmd_byte[7];
                     end
                     CMD_STOP: begin
                        st     <= ENG_STOP;
                        sda_oe <= 1'b1;
                     end
                     default: ;
                  endcase
               end
            end
            ENG_START: begin
               if (tick) begin
                  ph <= ph + 2'd1;
                  case (ph)
                     2'd0: scl_oe <= 1'b0;
                     2'd1: sda_oe <= 1'b1;
                     2'd2: scl_oe <= 1'b1;
                     default: begin
                        st     <= ENG_BIT;
                        bitn   <= 4'd0;
                        sda_oe <= ~sh[7];
                     end
                  endcase
               end
            end
            ENG_BIT: begin
               if (tick) begin
                  ph <= ph + 2'd1;
                  case (ph)
                     2'd1: scl_oe <= 1'b0;
                     2'd2: begin
                        if (bitn == 4'd8) ack_seen <= sda_s;
                        else              sh       <= {sh[6:0], sda_s};
                     end
                     2'd3: begin
                        scl_oe <= 1'b1;
                        if (bitn == 4'd8) begin
                           st        <= ENG_HOLD;
                           byte_done <= 1'b1;
                           sda_oe    <= 1'b0;
                        end else begin
                           bitn <= bitn + 4'd1;
                           if (bitn == 4'd7) sda_oe <= tx ? 1'b0 : ackd;
                           else              sda_oe <= tx & ~sh[7];
                        end
                     end
                     default: ;
                  endcase
               end
            end
            ENG_STOP: begin
               if (tick) begin
                  ph <= ph + 2'd1;
                  case (ph)
                     2'd0: scl_oe <= 1'b0;
                     2'd1: sda_oe <= 1'b0;
                     2'd3: begin
                        st   <= ENG_IDLE;
                        busy <= 1'b0;
                     end
                     default: ;
                  endcase
               end
            end
            default: st <= ENG_IDLE;
         endcase
      end
   end

   // R12: with SCL released, SDA moves only as part of START or STOP
   assert_sda_stable_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
         |-> (st == ENG_START || st == ENG_STOP));

   // R9: busy ends only by completing a STOP sequence
   assert_busy_ends_in_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(st) == ENG_STOP));

   // R5: the engine parks with SCL low after every byte
   assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> scl_oe);

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cm_pkg::*;
#(
   parameter int PRE_A       = 16,
   parameter int PRE_B       = 512,
   parameter int DIV_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       sda_in
);
   if (DIV_W < 1 || DIV_W > 4) begin : g_bad_div
      $error("DIV_W must fit the four-bit divisor field");
   end

   logic             acken, presel, ie, pend;
   logic [DIV_W-1:0] div;
   logic [1:0]       mode;
   logic             txen;
   logic [7:0]       data_r, own_r;
   queued_t          q_act;

   logic       wr_ctrl, wr_stat, wr_data, wr_own;
   logic       start_req, stop_req, clr_pend;
   logic       cmd_valid, cmd_tx, cmd_ack_drive;
   eng_cmd_t   cmd;
   logic       tick, run, eng_ready, eng_busy, byte_done, was_rx, ack_seen;
   logic [7:0] rx_byte;
   logic       sda_s;

   assign wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
   assign wr_stat = reg_we && (reg_addr == ADDR_STAT);
   assign wr_data = reg_we && (reg_addr == ADDR_DATA);
   assign wr_own  = reg_we && (reg_addr == ADDR_OWN);

   assign start_req = wr_stat && reg_wdata[SB_MASTER] && reg_wdata[SB_STRT] && reg_wdata[SB_TXEN];
   assign stop_req  = wr_stat && reg_wdata[SB_MASTER] && !reg_wdata[SB_STRT];
   assign clr_pend  = wr_ctrl && pend && !reg_wdata[CB_PEND];

   always_comb begin
      cmd_valid     = 1'b0;
      cmd           = CMD_BYTE;
      cmd_tx        = (mode == MODE_MT);
      cmd_ack_drive = clr_pend ? reg_wdata[CB_ACKEN] : acken;
      if (clr_pend && eng_ready) begin
         cmd_valid = 1'b1;
         case (q_act)
            Q_START: cmd = CMD_START;
            Q_STOP:  cmd = CMD_STOP;
            default: cmd = CMD_BYTE;
         endcase
      end else if (start_req && !eng_busy) begin
         cmd_valid = 1'b1;
         cmd       = CMD_START;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acken  <= 1'b0;
         presel <= 1'b0;
         ie     <= 1'b0;
         pend   <= 1'b0;
         div    <= '0;
         mode   <= 2'b00;
         txen   <= 1'b0;
         data_r <= 8'd0;
         own_r  <= 8'd0;
         q_act  <= Q_NONE;
      end else begin
         if (wr_ctrl) begin
            acken  <= reg_wdata[CB_ACKEN];
            presel <= reg_wdata[CB_PRESEL];
            ie     <= reg_wdata[CB_IE];
            div    <= reg_wdata[DIV_W-1:0];
         end
         if (byte_done)     pend <= 1'b1;
         else if (clr_pend) pend <= 1'b0;
         if (wr_stat) begin
            mode <= reg_wdata[SB_MASTER:SB_MTX];
            txen <= reg_wdata[SB_TXEN];
         end
         if (wr_data)                  data_r <= reg_wdata;
         else if (byte_done && was_rx) data_r <= rx_byte;
         if (wr_own) own_r <= reg_wdata;
         if (clr_pend)                  q_act <= Q_NONE;
         else if (start_req && eng_busy) q_act <= Q_START;
         else if (stop_req && eng_busy)  q_act <= Q_STOP;
      end
   end

   always_comb begin
      case (reg_addr)
         ADDR_CTRL: reg_rdata = {acken, presel, ie, pend, 4'(div)};
         ADDR_STAT: reg_rdata = {mode, eng_busy, txen, 3'b000, ack_seen};
         ADDR_DATA: reg_rdata = data_r;
         default:   reg_rdata = own_r;
      endcase
   end

   assign irq = pend & ie;

   i2cm_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sda_in),
      .q     (sda_s)
   );

   i2cm_quarter_gen #(.PRE_A(PRE_A), .PRE_B(PRE_B), .DIV_W(DIV_W)) u_qgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (run),
      .pre_sel (presel),
      .div     (div),
      .tick    (tick)
   );

   i2cm_bit_engine u_eng (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd           (cmd),
      .cmd_byte      (data_r),
      .cmd_tx        (cmd_tx),
      .cmd_ack_drive (cmd_ack_drive),
      .tick          (tick),
      .sda_s         (sda_s),
      .run           (run),
      .ready         (eng_ready),
      .busy          (eng_busy),
      .byte_done     (byte_done),
      .was_rx        (was_rx),
      .rx_byte       (rx_byte),
      .ack_seen      (ack_seen),
      .scl_oe        (scl_oe),
      .sda_oe        (sda_oe)
   );

   // R4: a finished byte always raises pending on the next cycle
   assert_pend_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> pend);

   // R5: SCL is kept low for as long as software has not cleared pending
   assert_stall_scl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && eng_busy) |-> scl_oe);

   // R3 / R10: commands reach the engine only when it can take them
   assert_cmd_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> eng_ready);

   // R9: a STOP never starts while pending is still set
   assert_stop_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && pend) |=> eng_busy);

endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
   localparam logic [6:0] SLV = 7'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       irq, scl_oe, sda_oe;
   logic       s_oe = 1'b0;
   logic       scl_bus, sda_bus;

   assign scl_bus = ~scl_oe;
   assign sda_bus = ~(sda_oe | s_oe);

   i2c_byte_master dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_bus)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // SCL period monitor at the port
   int cyc = 0, last_rise = 0, per = 0;
   logic prev_scl_oe = 1'b0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (prev_scl_oe && !scl_oe) begin
         per <= cyc - last_rise;
         last_rise <= cyc;
      end
      prev_scl_oe <= scl_oe;
   end

   function automatic logic [7:0] rbyte(input int i);
      return 8'hA5 ^ 8'(i * 59);
   endfunction

   // Slave model on the wired-AND bus
   int s_ph = 0;  // 0 idle, 1 addr, 2 write, 3 read
   int s_bit = 0, ridx = 0, wcnt = 0, starts = 0, stops = 0;
   logic s_skip = 1'b0, s_match = 1'b0, s_rw = 1'b0, s_mack = 1'b0;
   logic p_scl = 1'b1, p_sda = 1'b1;
   logic [7:0] s_sh = 8'd0, s_tx = 8'd0;
   logic [7:0] wlog [0:15];

   always @(scl_bus or sda_bus) begin
      if ((sda_bus != p_sda) && scl_bus && p_scl) begin
         if (!sda_bus) begin
            s_ph = 1; s_bit = 0; s_skip = 1'b1; s_sh = 8'd0; ridx = 0; starts++;
         end else begin
            s_ph = 0; s_oe = 1'b0; stops++;
         end
      end else if (scl_bus && !p_scl) begin
         if (s_ph != 0) begin
            if (s_bit < 8) s_sh = {s_sh[6:0], sda_bus};
            else if (s_ph == 3) s_mack = sda_bus;
         end
      end else if (!scl_bus && p_scl) begin
         if (s_skip) s_skip = 1'b0;
         else if (s_ph != 0) begin
            s_bit++;
            if (s_bit == 8) begin
               if (s_ph == 1) begin
                  s_match = (s_sh[7:1] == SLV); s_rw = s_sh[0]; s_oe = s_match;
               end else if (s_ph == 2) begin
                  wlog[wcnt % 16] = s_sh; wcnt++; s_oe = 1'b1;
               end else s_oe = 1'b0;
            end else if (s_bit == 9) begin
               s_bit = 0; s_oe = 1'b0;
               if (s_ph == 1) begin
                  if (!s_match) s_ph = 0;
                  else if (s_rw) begin
                     s_ph = 3; s_tx = rbyte(ridx); s_oe = ~s_tx[7];
                  end else s_ph = 2;
               end else if (s_ph == 3) begin
                  if (!s_mack) begin
                     ridx++; s_tx = rbyte(ridx); s_oe = ~s_tx[7];
                  end else s_ph = 0;
               end
            end else if (s_ph == 3) s_oe = ~s_tx[7 - s_bit];
         end
      end
      p_scl = scl_bus;
      p_sda = sda_bus;
   end

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk); reg_addr = a; #1; v = reg_rdata;
   endtask

   task automatic wait_pend(input string req);
      logic [7:0] v;
      int n = 0;
      do begin rd(2'd0, v); n++; end while (!v[4] && n < 20000);
      check(req, "pending reached", 32'(v[4]), 32'd1);
   endtask

   task automatic wait_idle(input string req);
      logic [7:0] v;
      int n = 0;
      do begin rd(2'd1, v); n++; end while (v[5] && n < 20000);
      check(req, "busy dropped", 32'(v[5]), 32'd0);
   endtask

   task automatic finish_stop(input logic [7:0] stat, input logic [7:0] ctrl);
      wr(2'd1, stat); wr(2'd0, ctrl); wait_idle("R9");
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v); check("R1", "register reset value", 32'(v), 32'd0);
      end
      check("R1", "irq reset", 32'(irq), 0);
      check("R1", "bus released", {30'd0, scl_oe, sda_oe}, 0);
   endtask

   task automatic t_regs();
      logic [7:0] v;
      wr(2'd3, 8'h5C); rd(2'd3, v); check("R2", "own address", 32'(v), 32'h5C);
      wr(2'd0, 8'h5F); rd(2'd0, v); check("R2", "pending not settable", 32'(v), 32'h4F);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_write();
      logic [7:0] v;
      int st0, sp0, w0;
      wr(2'd0, 8'hA0); wr(2'd1, 8'h10); wr(2'd2, {SLV, 1'b0});
      st0 = starts; sp0 = stops; w0 = wcnt;
      wr(2'd1, 8'hF0); rd(2'd1, v); check("R3", "status busy after START", 32'(v), 32'hF0);
      wait_pend("R4");
      rd(2'd1, v); check("R6", "address ACK", 32'(v[0]), 0);
      check("R4", "irq with enable", 32'(irq), 1);
      check("R3", "slave saw START", 32'(starts), 32'(st0 + 1));
      check("R3", "address matched MSB first", 32'(s_match), 1);
      repeat (40) @(negedge clk);
      check("R5", "SCL held low while pending", 32'(scl_oe), 1);
      check("R5", "slave saw no more bytes", 32'(wcnt), 32'(w0));
      wr(2'd2, 8'h5A); wr(2'd0, 8'hA0);
      rd(2'd0, v); check("R2", "pending cleared by write of 0", 32'(v[4]), 0);
      wait_pend("R7");
      check("R11", "SCL period prescale 16 div 0", 32'(per), 32'd16);
      check("R7", "slave received data byte", 32'(wlog[w0 % 16]), 32'h5A);
      rd(2'd1, v); check("R6", "data ACK", 32'(v[0]), 0);
      wr(2'd1, 8'hD0); repeat (30) @(negedge clk);
      check("R9", "STOP waits for pending clear", 32'(stops), 32'(sp0));
      check("R9", "SCL still held", 32'(scl_oe), 1);
      wr(2'd0, 8'hA0); wait_idle("R9");
      check("R9", "slave saw STOP", 32'(stops), 32'(sp0 + 1));
      check("R9", "bus released after STOP", {30'd0, scl_oe, sda_oe}, 0);
      rd(2'd0, v); check("R4", "no pending after STOP", 32'(v[4]), 0);
   endtask

   task automatic t_nack();
      logic [7:0] v;
      wr(2'd2, {7'h11, 1'b0}); wr(2'd1, 8'hF0); wait_pend("R4");
      rd(2'd1, v); check("R6", "unmatched address reads NACK", 32'(v[0]), 1);
      finish_stop(8'hD0, 8'hA0);
   endtask

   task automatic t_div();
      wr(2'd0, 8'hA2); wr(2'd2, {SLV, 1'b0}); wr(2'd1, 8'hF0); wait_pend("R4");
      check("R11", "SCL period prescale 16 div 2", 32'(per), 32'd48);
      finish_stop(8'hD0, 8'hA2);
      wr(2'd0, 8'hE0); wr(2'd1, 8'hF0); wait_pend("R4");
      check("R11", "SCL period prescale 512 div 0", 32'(per), 32'd512);
      finish_stop(8'hD0, 8'hE0);
   endtask

   task automatic t_read();
      logic [7:0] v;
      wr(2'd0, 8'hA0); wr(2'd2, {SLV, 1'b1}); wr(2'd1, 8'hB0); wait_pend("R4");
      rd(2'd1, v); check("R6", "read address ACK", 32'(v[0]), 0);
      wr(2'd0, 8'hA0); wait_pend("R8");
      rd(2'd2, v); check("R8", "first received byte", 32'(v), 32'(rbyte(0)));
      rd(2'd1, v); check("R8", "master ACK on bus", 32'(v[0]), 0);
      check("R8", "slave saw master ACK", 32'(s_mack), 0);
      wr(2'd0, 8'h20); wait_pend("R8");
      rd(2'd2, v); check("R8", "last received byte", 32'(v), 32'(rbyte(1)));
      rd(2'd1, v); check("R8", "master NACK on bus", 32'(v[0]), 1);
      check("R8", "slave saw master NACK", 32'(s_mack), 1);
      finish_stop(8'h90, 8'h20);
   endtask

   task automatic t_restart();
      logic [7:0] v;
      int st0, w0;
      wr(2'd0, 8'hA0); wr(2'd2, {SLV, 1'b0}); wr(2'd1, 8'hF0); wait_pend("R4");
      w0 = wcnt;
      wr(2'd2, 8'h07); wr(2'd0, 8'hA0); wait_pend("R7");
      check("R7", "register byte written", 32'(wlog[w0 % 16]), 32'h07);
      st0 = starts;
      wr(2'd2, {SLV, 1'b1}); wr(2'd1, 8'hB0); repeat (30) @(negedge clk);
      check("R10", "repeated START queued", 32'(starts), 32'(st0));
      wr(2'd0, 8'hA0); wait_pend("R10");
      check("R10", "repeated START issued", 32'(starts), 32'(st0 + 1));
      rd(2'd1, v); check("R10", "address ACK after repeated START", 32'(v[0]), 0);
      wr(2'd0, 8'h20); wait_pend("R8");
      rd(2'd2, v); check("R10", "read after repeated START", 32'(v), 32'(rbyte(0)));
      finish_stop(8'h90, 8'h20);
   endtask

   task automatic t_txen();
      logic [7:0] v;
      int st0 = starts;
      wr(2'd0, 8'hA0); wr(2'd2, {SLV, 1'b0}); wr(2'd1, 8'hE0); repeat (50) @(negedge clk);
      rd(2'd1, v); check("R3", "START without output enable ignored", 32'(v[5]), 0);
      check("R3", "no bus activity", 32'(scl_oe) + 32'(starts - st0), 0);
   endtask

   task automatic t_idle_stop();
      logic [7:0] v;
      int sp0 = stops;
      wr(2'd1, 8'hD0); repeat (50) @(negedge clk);
      rd(2'd1, v); check("R9", "STOP while idle leaves busy clear", 32'(v[5]), 0);
      check("R9", "STOP while idle no bus effect", {30'd0, scl_oe, sda_oe} + 32'(stops - sp0), 0);
   endtask

   task automatic t_irq_mask();
      wr(2'd0, 8'h80); wr(2'd2, {SLV, 1'b0}); wr(2'd1, 8'hF0); wait_pend("R4");
      check("R4", "irq masked by enable bit", 32'(irq), 0);
      finish_stop(8'hD0, 8'h80);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_regs();
      t_write();
      t_nack();
      t_div();
      t_read();
      t_restart();
      t_txen();
      t_idle_stop();
      t_irq_mask();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule